// File: doc/BRIEF.md
# Divided Pixel-Strobe Video Port Transmitter

This block drives pixel words onto a parallel video port. A fast port clock runs the whole block. From it the block builds a slower pixel strobe whose period is set by an 8-bit divisor. The strobe is a registered output, so both of its edges leave on a rising edge of the port clock. Each strobe period carries exactly one pixel. The pixel is taken from a valid/ready source when the period begins, and the data bus holds it for the whole period. A configuration bit selects where the strobe edge falls inside the period. In one setting the period opens with the strobe high, so a receiver can capture on the falling edge. In the other it opens low and rises part-way through, for rising-edge capture.

The receiver can stop the port with a stall input. While stall is high, no new period begins. A period that is already under way runs to its end. After stall drops, it must stay low for four port-clock samples in a row before a new period may start. The port clock keeps running the whole time. Any pixel waiting at the source stays there and goes out once the port resumes.

Top module: `vport_tx`

## Requirements
- R1: While rst_n is low, vp_strobe is 0, vp_data is 0 and pix_ready is 0.
- R2: With pixels always offered and stall low, a new strobe period starts every D port-clock cycles, where D is the effective divisor, and each period carries one pixel.
- R3: Let k = 0..D-1 count the cycles after the edge that starts a period, and H = floor(D/2). With cfg_fall_edge=1 the strobe is high for k < H and low otherwise. With cfg_fall_edge=0 it is low for k < D-H and high otherwise. Between periods the strobe is low.
- R4: A cfg_div value of 0 or 1 behaves exactly like 2.
- R5: vp_data changes only on the edge that starts a period, where it takes the accepted pixel. It then holds that value until the next acceptance.
- R6: A pixel is accepted on a clock edge where pix_valid and pix_ready are both 1. pix_ready is 1 only when no period is running, or when the running period is in its last cycle. Pixels go out in order, with none lost and none repeated.
- R7: While stall_in is 1, pix_ready is 0 and no period starts. A period already in progress completes. A pixel that is pending stays at the source and is sent after the stall.
- R8: A period starts on an edge only if stall_in is sampled 0 on that edge and on the three edges before it. The count starts from zero at reset, so the strobe first goes high 4 cycles after reset release or after stall drops.
- R9: With pix_valid low, the strobe stays low after the running period ends, and vp_data keeps its value.
- R10: cfg_div and cfg_fall_edge are captured when a period starts. A change during a period affects only later periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_div | input | 8 | Strobe period in port-clock cycles (0 and 1 act as 2) |
| cfg_fall_edge | input | 1 | 1: period opens high (falling-edge capture); 0: period opens low (rising-edge capture) |
| stall_in | input | 1 | Receiver stall request |
| pix_valid | input | 1 | Source has a pixel |
| pix_data | input | 24 | Source pixel word |
| pix_ready | output | 1 | Block accepts the pixel on this edge |
| vp_strobe | output | 1 | Divided pixel strobe |
| vp_data | output | 24 | Pixel data bus |

## Verification
The bench sweeps divisors 0 through 9 and 255 in both edge settings. For every cycle it compares the strobe level, the data word and the ready flag against values worked out from the period arithmetic. A design that rounded the high time the wrong way, or treated divisor 0 or 1 as a zero-length period, would show a wrong strobe level in some cycle or a wrong gap between rising edges. A stall is raised in the middle of a period. A design that cut the period short, dropped the waiting pixel or started too early would show the wrong strobe pattern, the wrong next data word, or a rising edge before the fourth cycle after release. A short stall glitch checks that the four-cycle wait restarts after any high sample. A divisor change in the middle of a period checks that a design which reads the configuration live would bend the current period.

// File: rtl/vport_tx_pkg.sv
package vport_tx_pkg;
  typedef enum logic {CAP_RISE = 1'b0, CAP_FALL = 1'b1} cap_edge_e;
  localparam int unsigned MIN_DIV = 2;
endpackage

// File: rtl/vport_div_clamp.sv
module vport_div_clamp #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_raw,
  output logic [DIV_W-1:0] div_eff,
  output logic [DIV_W-1:0] hi_len,
  output logic [DIV_W-1:0] lo_len
);
  import vport_tx_pkg::*;

  // Divisors below the minimum would give a strobe with no low or no high phase.
  always_comb begin
    if (div_raw < DIV_W'(MIN_DIV)) div_eff = DIV_W'(MIN_DIV);
    else                           div_eff = div_raw;
    hi_len = div_eff >> 1;
    lo_len = div_eff - hi_len;
  end
endmodule

// File: rtl/vport_wake_gate.sv
module vport_wake_gate #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_in,
  output logic go_ok
);
  localparam int QW = $clog2(WAKE_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(WAKE_CYC - 1);

  logic [QW-1:0] quiet_q, quiet_d;

  // Counts stall-free samples on earlier edges, saturating one short of the window.
  always_comb begin
    if (stall_in)              quiet_d = '0;
    else if (quiet_q == QMAX)  quiet_d = quiet_q;
    else                       quiet_d = quiet_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_q <= '0;
    else        quiet_q <= quiet_d;
  end

  // The current sample plus the saturated history make up the full window.
  assign go_ok = !stall_in && (quiet_q == QMAX);
endmodule

// File: rtl/vport_strobe_seq.sv
module vport_strobe_seq #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DIV_W-1:0] div_eff,
  input  logic [DIV_W-1:0] hi_len,
  input  logic [DIV_W-1:0] lo_len,
  input  logic             cap_fall,
  output logic             slot_free,
  output logic             strobe
);
  import vport_tx_pkg::*;

  logic             act_q,  act_d;
  logic [DIV_W-1:0] cnt_q,  cnt_d;
  logic [DIV_W-1:0] div_q,  hi_q, lo_q;
  logic             fall_q;
  logic             stb_q,  stb_d;
  logic             last_cyc, cnt_en;
  logic [DIV_W-1:0] hi_n, lo_n;
  logic             fall_n;

  assign last_cyc  = act_q && (cnt_q == div_q - DIV_W'(1));
  assign slot_free = !act_q || last_cyc;
  assign cnt_en    = take || act_q;

  // Settings that apply to the coming cycle: fresh ones on a start, held ones otherwise.
  assign hi_n   = take ? hi_len : hi_q;
  assign lo_n   = take ? lo_len : lo_q;
  assign fall_n = take ? cap_fall : fall_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (take) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (last_cyc) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q) begin
      cnt_d = cnt_q + DIV_W'(1);
    end
    if (!act_d)                           stb_d = 1'b0;
    else if (fall_n == 1'(CAP_FALL))      stb_d = (cnt_d < hi_n);
    else                                  stb_d = (cnt_d >= lo_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(MIN_DIV);
      hi_q   <= '0;
      lo_q   <= '0;
      fall_q <= 1'b0;
    end else if (take) begin
      div_q  <= div_eff;
      hi_q   <= hi_len;
      lo_q   <= lo_len;
      fall_q <= cap_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign strobe = stb_q;
endmodule

// File: rtl/vport_tx.sv
module vport_tx #(
  parameter int DATA_W   = 24,
  parameter int DIV_W    = 8,
  parameter int WAKE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_fall_edge,
  input  logic              stall_in,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              vp_strobe,
  output logic [DATA_W-1:0] vp_data
);
  logic [DIV_W-1:0]  div_eff, hi_len, lo_len;
  logic              go_ok, slot_free, take;
  logic [DATA_W-1:0] data_q;

  vport_div_clamp #(.DIV_W(DIV_W)) u_clamp (
    .div_raw (cfg_div),
    .div_eff (div_eff),
    .hi_len  (hi_len),
    .lo_len  (lo_len)
  );

  vport_wake_gate #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_in (stall_in),
    .go_ok    (go_ok)
  );

  vport_strobe_seq #(.DIV_W(DIV_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .div_eff   (div_eff),
    .hi_len    (hi_len),
    .lo_len    (lo_len),
    .cap_fall  (cfg_fall_edge),
    .slot_free (slot_free),
    .strobe    (vp_strobe)
  );

  assign pix_ready = slot_free && go_ok;
  assign take      = pix_ready && pix_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (take) data_q <= pix_data;
  end

  assign vp_data = data_q;
endmodule

// File: rtl/vport_tx_chk.sv
module vport_tx_chk #(
  parameter int DATA_W   = 24,
  parameter int WAKE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_in,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [DATA_W-1:0] vp_data
);
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= '0;
    else if (stall_in)      low_run <= '0;
    else if (low_run != '1) low_run <= low_run + 8'd1;
  end

  // R7
  stall_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_in |-> !pix_ready);

  // R8
  wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |-> (!stall_in && (low_run >= 8'(WAKE_CYC - 1))));

  // R6
  one_per_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> !pix_ready);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pix_ready) |=> $stable(vp_data));
endmodule

bind vport_tx vport_tx_chk #(.DATA_W(DATA_W), .WAKE_CYC(WAKE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall_in  (stall_in),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .vp_data   (vp_data)
);

// File: tb/vport_tx_bench.sv
module vport_tx_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_div;
  logic        cfg_fall_edge;
  logic        stall_in;
  logic        pix_valid;
  logic [23:0] pix_data;
  logic        pix_ready;
  logic        vp_strobe;
  logic [23:0] vp_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  vport_tx u_vport_tx (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fall_edge(cfg_fall_edge),
    .stall_in(stall_in), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .vp_strobe(vp_strobe), .vp_data(vp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      report();
    end
  end

  task automatic stream_case(int dv, bit fe, int npix);
    int d, h, l, acc, first_rise, second_rise;
    bit upd, prev_stb;
    logic [23:0] base;
    d = (dv < 2) ? 2 : dv;
    h = d / 2;
    l = d - h;
    base = 24'((dv << 12) | (int'(fe) << 8) | 16);
    @(negedge clk);
    cfg_div = 8'(dv); cfg_fall_edge = fe; pix_valid = 1'b1; pix_data = base;
    #1;
    while (!pix_ready) @(negedge clk);
    acc = 1; upd = 1; first_rise = -1; second_rise = -1; prev_stb = 1'b0;
    for (int j = 0; j < npix * d; j++) begin
      @(negedge clk);
      if (upd) begin
        pix_data = base + 24'(acc);
        if (acc == npix) pix_valid = 1'b0;
        upd = 0;
      end
      // R3 strobe level per cycle of the period
      check("R3", int'(vp_strobe), int'(fe ? ((j % d) < h) : ((j % d) >= l)));
      // R5 data held for the whole period
      check("R5", int'(vp_data), int'(base + 24'(j / d)));
      // R6 ready only in the closing cycle of a period
      check("R6", int'(pix_ready), int'((j % d) == d - 1));
      if (vp_strobe && !prev_stb) begin
        if (first_rise < 0) first_rise = j;
        else if (second_rise < 0) second_rise = j;
      end
      prev_stb = vp_strobe;
      if (pix_ready && pix_valid) begin
        acc++;
        upd = 1;
      end
    end
    // R2 rising edges spaced by the effective divisor
    check("R2", second_rise - first_rise, d);
    if (dv < 2) check("R4", second_rise - first_rise, 2);
    check("R6", acc, npix);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9", int'(vp_strobe), 0);
      check("R9", int'(vp_data), int'(base + 24'(npix - 1)));
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_div = 8'd4; cfg_fall_edge = 1'b1; stall_in = 1'b0;
    pix_valid = 1'b1; pix_data = 24'hABCDEF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(vp_strobe), 0);
    check("R1", int'(vp_data), 0);
    check("R1", int'(pix_ready), 0);
    rst_n = 1'b1;
    #1;
    check("R8", int'(pix_ready), 0);
    for (int q = 1; q <= 4; q++) begin
      @(negedge clk);
      if (q == 4) pix_valid = 1'b0;
      // R8 first strobe four cycles after reset release
      check("R8", int'(vp_strobe), int'(q == 4));
    end
    check("R5", int'(vp_data), 24'hABCDEF);
    repeat (6) @(negedge clk);

    for (int dv = 0; dv <= 10; dv++) begin
      for (int fe = 0; fe < 2; fe++) begin
        stream_case((dv == 10) ? 255 : dv, fe[0], 3);
      end
    end

    // R7 stall in mid-period, pending pixel held, R8 wake timing
    @(negedge clk);
    cfg_div = 8'd4; cfg_fall_edge = 1'b1; pix_valid = 1'b1; pix_data = 24'h0A0001;
    #1;
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
    pix_data = 24'h0A0002;
    check("R7", int'(vp_strobe), 1);
    stall_in = 1'b1;
    #1;
    check("R7", int'(pix_ready), 0);
    for (int j = 1; j < 12; j++) begin
      @(negedge clk);
      check("R7", int'(vp_strobe), int'(j == 1));
      check("R7", int'(pix_ready), 0);
      check("R7", int'(vp_data), 24'h0A0001);
    end
    stall_in = 1'b0;
    for (int q = 1; q <= 4; q++) begin
      @(negedge clk);
      if (q < 4) check("R8", int'(pix_ready), int'(q == 3));
      check("R8", int'(vp_strobe), int'(q == 4));
      if (q == 4) begin
        check("R7", int'(vp_data), 24'h0A0002);
        pix_valid = 1'b0;
      end
    end
    repeat (4) @(negedge clk);

    // R8 a short stall glitch restarts the window
    stall_in = 1'b1;
    repeat (3) @(negedge clk);
    stall_in = 1'b0;
    pix_valid = 1'b1; pix_data = 24'h0A0003;
    repeat (2) begin
      @(negedge clk);
      check("R8", int'(vp_strobe), 0);
    end
    stall_in = 1'b1;
    @(negedge clk);
    check("R8", int'(vp_strobe), 0);
    stall_in = 1'b0;
    for (int q = 1; q <= 4; q++) begin
      @(negedge clk);
      check("R8", int'(vp_strobe), int'(q == 4));
      if (q == 4) begin
        check("R8", int'(vp_data), 24'h0A0003);
        pix_valid = 1'b0;
      end
    end
    repeat (6) @(negedge clk);

    // R10 configuration change inside a period
    cfg_div = 8'd4; cfg_fall_edge = 1'b1; pix_valid = 1'b1; pix_data = 24'h0B0001;
    #1;
    while (!pix_ready) @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j == 0) begin pix_data = 24'h0B0002; cfg_div = 8'd6; end
      if (j == 4) pix_valid = 1'b0;
      if (j == 5) cfg_fall_edge = 1'b0;
      check("R10", int'(vp_strobe), int'((j < 4) ? (j < 2) : ((j - 4) < 3)));
      check("R10", int'(vp_data), (j < 4) ? 24'h0B0001 : 24'h0B0002);
    end
    repeat (4) @(negedge clk);
    report();
  end
endmodule